// File: doc/BRIEF.md
# IDE Controller Interrupt Routing Unit

This block steers the interrupt requests of a two-channel IDE controller function onto the two legacy ISA-style lines, IRQ14 and IRQ15. It holds a small slice of the function's configuration space: the programming-interface byte, whose per-channel mode bits pick legacy or native operation; one status byte per channel that mirrors that channel's request; and an interrupt-line byte that reads back a fixed value. The interrupt-line byte plays no part in routing. A static board strap forces the fixed legacy routing whatever the mode bits say.

Routing is chosen per channel. The primary channel always appears on IRQ14. The secondary channel appears on IRQ15 when it is in legacy mode or when the strap is set. When the secondary channel is native and the strap is clear, it shares IRQ14 with the primary channel. Even in native mode, nothing is sent to a PCI INTx pin.

The configuration port is a plain single-cycle register port. Writes take effect at the clock edge on which `cfg_wr_en` is high. Reads are combinational from `cfg_addr`. The port has no back-pressure, so no valid/ready handshake is needed.

Top module: `ide_irq_steer`

## Requirements
- R1: After reset the programming-interface byte (offset 0x09) reads 0x8F, both status bytes read 0x00, and `irq14` and `irq15` are low.
- R2: A write to offset 0x09 changes only bit 0 (primary native) and bit 2 (secondary native): new = (old & ~0x05) | (wdata & 0x05). The other bits keep their reset values.
- R3: The interrupt-line byte at offset 0x3C always reads `INTLINE_VAL` (default 0x0E). Writes to it are ignored and have no effect on either IRQ output.
- R4: Bit 7 of the status byte (0x70 for the primary channel, 0x78 for the secondary) equals that channel's request as sampled at the previous clock edge. Its other bits read 0. Configuration writes to these bytes have no effect.
- R5: A primary request drives `irq14` in both legacy and native mode, with the strap set or clear.
- R6: When the secondary channel is in legacy mode (bit 2 clear) or the strap is high, a secondary request drives `irq15` and does not drive `irq14`.
- R7: When the secondary channel is native and the strap is low, `irq15` stays low and `irq14` is the OR of both channel requests.
- R8: The IRQ outputs are registered. They change one clock edge after a change on a request input, a mode write or a strap change, and never within the same cycle.
- R9: A read from any offset that is not one of the four mapped bytes returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | 2 | Interrupt requests; bit 0 is the primary channel, bit 1 the secondary |
| strap_legacy | input | 1 | Board strap; when high it forces the fixed legacy line for each channel |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| irq14 | output | 1 | Legacy interrupt line 14, active high |
| irq15 | output | 1 | Legacy interrupt line 15, active high |

## Verification
If a mode bit is latched wrongly, the fault shows at the ports one edge after the next secondary request. That request then lands on the wrong line: IRQ14 instead of IRQ15, or the reverse. The same fault is also visible at once on a read of offset 0x09. A status register that lags or sticks shows as a stale bit 7 at 0x70 or 0x78 on the cycle after the request changes. A leak through the write mask or through the read-only bytes changes the read-back value right after the write. The directed tests therefore read back each register and check both lines one edge after every stimulus.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 8;
  localparam int NUM_CH = 2;

  // Configuration offsets that other decode logic relies on
  localparam logic [CFG_AW-1:0] OFF_PROGIF    = 8'h09;
  localparam logic [CFG_AW-1:0] OFF_INTLINE   = 8'h3C;
  localparam logic [CFG_AW-1:0] OFF_STAT_BASE = 8'h70;
  localparam logic [CFG_AW-1:0] OFF_STAT_STEP = 8'h08;

  localparam logic [CFG_DW-1:0] PROGIF_RST   = 8'h8F;
  localparam logic [CFG_DW-1:0] PROGIF_WMASK = 8'h05;
  localparam int STAT_ACT_BIT = 7;

  // Native-mode bit for channel ch sits at bit 2*ch of the programming interface
  function automatic int native_bit(input int ch);
    return 2 * ch;
  endfunction
endpackage

// File: rtl/ide_irq_chan_stat.sv
module ide_irq_chan_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic active_o
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      armed    <= 1'b0;
    end else begin
      active_o <= req_i;
      armed    <= 1'b1;
    end
  end

  // R4: status bit mirrors the request of the previous edge
  a_r4_status_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (active_o == $past(req_i)));
endmodule

// File: rtl/ide_irq_progif.sv
module ide_irq_progif
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output logic [CFG_DW-1:0] progif_q,
  output logic [CFG_DW-1:0] progif_d
);
  logic hit;
  logic armed;

  assign hit = wr_en_i && (addr_i == OFF_PROGIF);

  always_comb begin
    progif_d = progif_q;
    if (hit) progif_d = (progif_q & ~PROGIF_WMASK) | (wdata_i & PROGIF_WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      progif_q <= PROGIF_RST;
      armed    <= 1'b0;
    end else begin
      progif_q <= progif_d;
      armed    <= 1'b1;
    end
  end

  // R2: a write to the byte only moves the two mode bits
  a_r2_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_en_i && (addr_i == OFF_PROGIF))) |->
      (progif_q == (($past(progif_q) & ~PROGIF_WMASK) | ($past(wdata_i) & PROGIF_WMASK))));

  // R2: without a write the byte holds
  a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(wr_en_i && (addr_i == OFF_PROGIF))) |-> $stable(progif_q));

  // R1/R2: bits outside the mask keep their reset value
  a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((progif_q & ~PROGIF_WMASK) == (PROGIF_RST & ~PROGIF_WMASK)));
endmodule

// File: rtl/ide_irq_route.sv
module ide_irq_route
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] native_i,
  input  logic              strap_i,
  output logic              irq14_o,
  output logic              irq15_o
);
  logic [NUM_CH-1:0] fixed_line;  // channel uses its own legacy line
  logic              irq14_d;
  logic              irq15_d;
  logic              armed;

  // Primary's own line is 14, so both its modes end on 14.
  assign fixed_line = ~native_i | {NUM_CH{strap_i}};
  assign irq14_d    = req_i[0] | (req_i[1] & ~fixed_line[1]);
  assign irq15_d    = req_i[1] & fixed_line[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq14_o <= 1'b0;
      irq15_o <= 1'b0;
      armed   <= 1'b0;
    end else begin
      irq14_o <= irq14_d;
      irq15_o <= irq15_d;
      armed   <= 1'b1;
    end
  end

  // R5: primary request always shows on IRQ14
  a_r5_primary_on_14: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_i[0])) |-> irq14_o);

  // R6: legacy or strapped secondary lands on IRQ15
  a_r6_secondary_on_15: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!native_i[1] || strap_i)) |-> (irq15_o == $past(req_i[1])));

  // R7: native unstrapped secondary shares IRQ14
  a_r7_shared_14: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(native_i[1] && !strap_i)) |-> (!irq15_o && (irq14_o == $past(|req_i))));

  // R8: nothing moves IRQ15 without a secondary request one edge earlier
  a_r8_no_spurious_15: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && irq15_o) |-> $past(req_i[1]));
endmodule

// File: rtl/ide_irq_steer.sv
module ide_irq_steer
  import ide_irq_pkg::*;
#(
  parameter logic [7:0] INTLINE_VAL = 8'h0E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] chan_req,
  input  logic       strap_legacy,
  input  logic       cfg_wr_en,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       irq14,
  output logic       irq15
);
  logic [CFG_DW-1:0] progif_q;
  logic [CFG_DW-1:0] progif_d;
  logic [NUM_CH-1:0] stat_act;
  logic [NUM_CH-1:0] native_next;
  logic [NUM_CH-1:0] stat_hit;
  logic [CFG_DW-1:0] stat_rd;

  ide_irq_progif u_progif (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (cfg_wr_en),
    .addr_i   (cfg_addr),
    .wdata_i  (cfg_wdata),
    .progif_q (progif_q),
    .progif_d (progif_d)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam logic [CFG_AW-1:0] STAT_OFF = OFF_STAT_BASE + CFG_AW'(ch) * OFF_STAT_STEP;

    ide_irq_chan_stat u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (chan_req[ch]),
      .active_o (stat_act[ch])
    );

    assign native_next[ch] = progif_d[native_bit(ch)];
    assign stat_hit[ch]    = (cfg_addr == STAT_OFF);
  end

  ide_irq_route u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (chan_req),
    .native_i (native_next),
    .strap_i  (strap_legacy),
    .irq14_o  (irq14),
    .irq15_o  (irq15)
  );

  always_comb begin
    stat_rd = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (stat_hit[ch]) stat_rd[STAT_ACT_BIT] = stat_act[ch];
    end
  end

  always_comb begin
    if (cfg_addr == OFF_PROGIF)       cfg_rdata = progif_q;
    else if (cfg_addr == OFF_INTLINE) cfg_rdata = INTLINE_VAL;
    else if (|stat_hit)               cfg_rdata = stat_rd;
    else                              cfg_rdata = '0;
  end

  // R3: the interrupt-line byte reads its fixed value
  a_r3_intline_const: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == OFF_INTLINE) |-> (cfg_rdata == INTLINE_VAL));

  // R9: unmapped offsets read zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_addr != OFF_PROGIF) && (cfg_addr != OFF_INTLINE) && !(|stat_hit)) |-> (cfg_rdata == '0));
endmodule

// File: tb/ide_irq_steer_bench.sv
module ide_irq_steer_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chan_req = 2'b00;
  logic       strap_legacy = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       irq14, irq15;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_irq_steer u_ide_irq_steer (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .strap_legacy(strap_legacy),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq14(irq14), .irq15(irq15)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic drive_req(input logic [1:0] r);
    @(negedge clk);
    chan_req = r;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    cfg_read(8'h09, v); chk("R1 progif reset", v, 8'h8F);
    cfg_read(8'h70, v); chk("R1 pri status reset", v, 8'h00);
    cfg_read(8'h78, v); chk("R1 sec status reset", v, 8'h00);
    chk("R1 irq lines reset", {6'd0, irq15, irq14}, 8'h00);
  endtask

  task automatic t_progif_mask;
    logic [7:0] v;
    cfg_write(8'h09, 8'h00); cfg_read(8'h09, v); chk("R2 clear both", v, 8'h8A);
    cfg_write(8'h09, 8'hFF); cfg_read(8'h09, v); chk("R2 set all", v, 8'h8F);
    cfg_write(8'h09, 8'h74); cfg_read(8'h09, v); chk("R2 secondary only", v, 8'h8E);
    cfg_write(8'h09, 8'h8F);
  endtask

  task automatic t_readonly;
    logic [7:0] v;
    strap_legacy = 1'b0;
    cfg_write(8'h09, 8'h8F);
    cfg_write(8'h3C, 8'h0F); cfg_read(8'h3C, v); chk("R3 intline ignores write", v, 8'h0E);
    drive_req(2'b10);
    chk("R3 routing unaffected by intline", {6'd0, irq15, irq14}, 8'h01);
    drive_req(2'b00);
    cfg_write(8'h70, 8'hFF); cfg_read(8'h70, v); chk("R4 status write ignored", v, 8'h00);
    chk("R4 no irq from status write", {6'd0, irq15, irq14}, 8'h00);
    cfg_write(8'h78, 8'h80); cfg_read(8'h78, v); chk("R4 sec status write ignored", v, 8'h00);
    cfg_read(8'h71, v); chk("R9 unmapped 0x71", v, 8'h00);
    cfg_read(8'h00, v); chk("R9 unmapped 0x00", v, 8'h00);
  endtask

  task automatic t_matrix;
    logic [7:0] v;
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 4; m++) begin
        logic nat1;
        logic e14, e15;
        nat1 = m[1];
        strap_legacy = s[0];
        cfg_write(8'h09, {5'b01100, m[1], 1'b1, m[0]});
        for (int r = 0; r < 4; r++) begin
          drive_req(r[1:0]);
          // R5 primary always on 14; R6 legacy/strap secondary on 15; R7 shared 14
          e14 = r[0] | (r[1] & nat1 & ~s[0]);
          e15 = r[1] & (~nat1 | s[0]);
          chk($sformatf("R5 R6 R7 irq14 s=%0d m=%0d r=%0d", s, m, r), {7'd0, irq14}, {7'd0, e14});
          chk($sformatf("R6 R7 irq15 s=%0d m=%0d r=%0d", s, m, r), {7'd0, irq15}, {7'd0, e15});
          cfg_read(8'h70, v); chk("R4 pri status bit", v, {r[0], 7'd0});
          cfg_read(8'h78, v); chk("R4 sec status bit", v, {r[1], 7'd0});
        end
      end
    end
    drive_req(2'b00);
    strap_legacy = 1'b0;
  endtask

  task automatic t_timing;
    cfg_write(8'h09, 8'h8F);
    @(negedge clk);
    chan_req = 2'b10;
    #1;
    chk("R8 no same-cycle change", {6'd0, irq15, irq14}, 8'h00);
    @(negedge clk);
    chk("R8 one edge later on 14", {6'd0, irq15, irq14}, 8'h01);
    // mode write to legacy secondary moves the request to 15 one edge later
    @(negedge clk);
    cfg_addr = 8'h09; cfg_wdata = 8'h8B; cfg_wr_en = 1'b1;
    #1;
    chk("R8 write not yet visible", {6'd0, irq15, irq14}, 8'h01);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk("R8 write moved to 15", {6'd0, irq15, irq14}, 8'h02);
    cfg_write(8'h09, 8'h8F);
    @(negedge clk);
    strap_legacy = 1'b1;
    #1;
    chk("R8 strap not yet visible", {6'd0, irq15, irq14}, 8'h01);
    @(negedge clk);
    chk("R8 strap moved to 15", {6'd0, irq15, irq14}, 8'h02);
    strap_legacy = 1'b0;
    drive_req(2'b00);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_progif_mask();
    t_readonly();
    t_matrix();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule